// File: doc/BRIEF.md
# Scanout Line Position Estimator

This block estimates which line a display sink is scanning out at the moment of a query. The sink is fed from a line FIFO that an upstream compositor keeps topped up, so the compositor's own line counter runs ahead of the sink by roughly the FIFO's depth in lines. The estimator derives that depth from the FIFO's buffer bounds and the active width. It then subtracts the depth from the compositor line to produce a signed sink position. When the compositor is not far enough into the frame for that subtraction to mean anything, the sink must be in vertical blanking, and a fallback position is produced instead.

A query is a one-cycle strobe on `reqStrobe` with all inputs valid in the same cycle. One clock later the result appears on the outputs, marked by `doneStrobe`, and it stays there until the next query. The result consists of a vertical position, a horizontal offset that corrects for the second field of interlaced content, and three flags: valid, accurate and in-vblank.

Top module: `scanline_estimator`

## Requirements
- R1: A result is registered on the clock edge that samples `reqStrobe`. `doneStrobe` is high for exactly the following cycle. Without a strobe, every result output keeps its value.
- R2: The buffer size in pixels is (bufTop with bits [1:0] cleared) minus (bufBase with bits [1:0] cleared) plus 4.
- R3: The FIFO depth in lines is the buffer size divided by `activeWidth`, rounded down. An `activeWidth` of 0 gives a depth larger than any line number.
- R4: If `prodLine` is strictly greater than the depth, then `vPos` = prodLine − depth − 1, `posAccurate` = 1 and `inVblank` = 0.
- R5: If `prodLine` is less than or equal to the depth, then `inVblank` = 1.
- R6: In vblank with `fromVblankIrq` = 1, `vPos` = −(vTotal − vActive) and `posAccurate` is the inverse of `fifoFull`.
- R7: In vblank with `fromVblankIrq` = 0, `vPos` = 0 and `posAccurate` = 0.
- R8: `hPos` is hTotal/2 (rounded down) when `interlaced` = 1 and bit 0 of `frameCount` is 1. Otherwise `hPos` is 0.
- R9: Out of reset, `posValid`, `posAccurate`, `inVblank`, `doneStrobe`, `vPos` and `hPos` are all 0. Every registered result carries `posValid` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqStrobe | input | 1 | Query strobe, one cycle |
| prodLine | input | LINE_W | Line index reported by the compositor |
| frameCount | input | FRAME_W | Compositor frame counter |
| fifoFull | input | 1 | Compositor FIFO-full flag |
| bufTop | input | PIX_W | Upper bound of the FIFO buffer, in pixels |
| bufBase | input | PIX_W | Lower bound of the FIFO buffer, in pixels |
| activeWidth | input | LINE_W | Active pixels per line |
| vTotal | input | LINE_W | Total lines per frame |
| vActive | input | LINE_W | Active lines per frame |
| hTotal | input | LINE_W | Total pixels per line |
| interlaced | input | 1 | Interlaced mode |
| fromVblankIrq | input | 1 | Query was taken from the vblank interrupt |
| doneStrobe | output | 1 | Result updated in this cycle |
| vPos | output | LINE_W+1 | Signed estimated sink line |
| hPos | output | LINE_W | Horizontal field offset |
| posValid | output | 1 | Result valid |
| posAccurate | output | 1 | Result is an accurate estimate |
| inVblank | output | 1 | Sink is judged to be in vblank |

## Verification
The assertions rely on three properties of the inputs. The aligned top bound is never below the aligned base bound. `vTotal` is never below `vActive`. Inputs are presented in the same cycle as the strobe. Under these conditions, an accurate active-region result is never negative and a vblank result is never positive. The directed stimulus respects all three rules. It places the compositor line on both sides of the depth boundary. It sets the buffer bounds so that the low-bit masking and a zero width each change which side of the boundary a line falls on.

// File: rtl/sle_pkg.sv
package sle_pkg;

  // Strobes from control to datapath for one query
  typedef struct packed {
    logic load;          // capture a new result
    logic pickActive;    // use the FIFO-corrected compositor line
    logic pickIrqBlank;  // use minus the blanking height
    logic pickZero;      // use zero
    logic markAccurate;  // accuracy flag for this result
    logic markBlank;     // in-vblank flag for this result
    logic addHalf;       // add half a line to the horizontal offset
  } sleStrobes_t;

endpackage

// File: rtl/sle_divider.sv
// Unrolled restoring divider: one compare/subtract stage per quotient bit.
// A zero denominator yields an all-ones quotient.
module sle_divider #(
  parameter int NUM_W = 17,
  parameter int DEN_W = 12
) (
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic [NUM_W-1:0] quot
);

  logic [NUM_W-1:0][DEN_W-1:0] remChain;

  assign remChain[0] = '0;

  for (genvar s = 0; s < NUM_W; s++) begin : g_stage
    localparam int BIT = NUM_W - 1 - s;
    logic [DEN_W:0]   trial;
    logic             take;
    logic [DEN_W-1:0] diff;

    assign trial     = {remChain[s], numer[BIT]};
    assign take      = trial >= {1'b0, denom};
    assign diff      = trial[DEN_W-1:0] - denom;
    assign quot[BIT] = take;

    if (s < NUM_W - 1) begin : g_next
      assign remChain[s+1] = take ? diff : trial[DEN_W-1:0];
    end
  end

endmodule

// File: rtl/sle_ctrl.sv
// Decides which position source and which flags apply to a query.
module sle_ctrl
  import sle_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqStrobe,
  input  logic               aboveDepth,
  input  logic               fromVblankIrq,
  input  logic               fifoFull,
  input  logic               interlaced,
  input  logic [FRAME_W-1:0] frameCount,
  output sleStrobes_t        strb
);

  logic frameOdd;

  always_comb begin
    frameOdd          = (frameCount % 2) != 0;
    strb.load         = reqStrobe;
    strb.pickActive   = aboveDepth;
    strb.pickIrqBlank = !aboveDepth && fromVblankIrq;
    strb.pickZero     = !aboveDepth && !fromVblankIrq;
    strb.markAccurate = aboveDepth || (fromVblankIrq && !fifoFull);
    strb.markBlank    = !aboveDepth;
    strb.addHalf      = interlaced && frameOdd;
  end

  // R4 R5: exactly one position source per query
  assert_one_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |-> $onehot({strb.pickActive, strb.pickIrqBlank, strb.pickZero}));

  // R7: a non-interrupt vblank result is never accurate
  assert_zero_not_accurate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load && strb.pickZero |-> !strb.markAccurate);

endmodule

// File: rtl/sle_datapath.sv
// Buffer size, depth in lines, position arithmetic and result registers.
module sle_datapath
  import sle_pkg::*;
#(
  parameter int LINE_W = 12,
  parameter int PIX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sleStrobes_t       strb,
  input  logic [PIX_W-1:0]  bufTop,
  input  logic [PIX_W-1:0]  bufBase,
  input  logic [LINE_W-1:0] activeWidth,
  input  logic [LINE_W-1:0] prodLine,
  input  logic [LINE_W-1:0] vTotal,
  input  logic [LINE_W-1:0] vActive,
  input  logic [LINE_W-1:0] hTotal,
  output logic              aboveDepth,
  output logic              doneStrobe,
  output logic [LINE_W:0]   vPos,
  output logic [LINE_W-1:0] hPos,
  output logic              posValid,
  output logic              posAccurate,
  output logic              inVblank
);

  localparam int SIZE_W = PIX_W + 1;
  localparam int POS_W  = LINE_W + 1;

  logic [PIX_W-1:0]  topAligned, baseAligned;
  logic [SIZE_W-1:0] bufSize;
  logic [SIZE_W-1:0] depthLines;
  logic [SIZE_W-1:0] lineWide;
  logic [POS_W-1:0]  activePos, blankPos, nextPos;
  logic [LINE_W-1:0] nextH;

  always_comb begin
    topAligned  = bufTop & ~PIX_W'(3);
    baseAligned = bufBase & ~PIX_W'(3);
    bufSize     = {1'b0, topAligned} - {1'b0, baseAligned} + SIZE_W'(4);
  end

  sle_divider #(
    .NUM_W (SIZE_W),
    .DEN_W (LINE_W)
  ) u_div (
    .numer (bufSize),
    .denom (activeWidth),
    .quot  (depthLines)
  );

  always_comb begin
    lineWide   = SIZE_W'(prodLine);
    aboveDepth = lineWide > depthLines;
    activePos  = POS_W'(prodLine) - POS_W'(depthLines[LINE_W-1:0]) - POS_W'(1);
    blankPos   = POS_W'(vActive) - POS_W'(vTotal);
    if (strb.pickActive)        nextPos = activePos;
    else if (strb.pickIrqBlank) nextPos = blankPos;
    else                        nextPos = '0;
    nextH = strb.addHalf ? (hTotal >> 1) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      doneStrobe  <= 1'b0;
      vPos        <= '0;
      hPos        <= '0;
      posValid    <= 1'b0;
      posAccurate <= 1'b0;
      inVblank    <= 1'b0;
    end else begin
      doneStrobe <= strb.load;
      if (strb.load) begin
        vPos        <= nextPos;
        hPos        <= nextH;
        posValid    <= 1'b1;
        posAccurate <= strb.markAccurate;
        inVblank    <= strb.markBlank;
      end
    end
  end

  // R1: results hold between queries
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.load |=> $stable({vPos, hPos, posValid, posAccurate, inVblank}));

  // R9: every captured result is valid
  assert_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> posValid && doneStrobe);

  // R4: an active-region result is accurate and non-negative
  assert_active_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    posValid && !inVblank |-> posAccurate && !vPos[POS_W-1]);

  // R6 R7: a vblank result is never positive
  assert_blank_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    posValid && inVblank |-> vPos[POS_W-1] || (vPos == '0));

  // R8: no field offset unless requested
  assert_hpos_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load && !strb.addHalf |=> hPos == '0);

endmodule

// File: rtl/scanline_estimator.sv
module scanline_estimator
  import sle_pkg::*;
#(
  parameter int LINE_W  = 12,
  parameter int PIX_W   = 16,
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqStrobe,
  input  logic [LINE_W-1:0]  prodLine,
  input  logic [FRAME_W-1:0] frameCount,
  input  logic               fifoFull,
  input  logic [PIX_W-1:0]   bufTop,
  input  logic [PIX_W-1:0]   bufBase,
  input  logic [LINE_W-1:0]  activeWidth,
  input  logic [LINE_W-1:0]  vTotal,
  input  logic [LINE_W-1:0]  vActive,
  input  logic [LINE_W-1:0]  hTotal,
  input  logic               interlaced,
  input  logic               fromVblankIrq,
  output logic               doneStrobe,
  output logic [LINE_W:0]    vPos,
  output logic [LINE_W-1:0]  hPos,
  output logic               posValid,
  output logic               posAccurate,
  output logic               inVblank
);

  sleStrobes_t strb;
  logic        aboveDepth;

  sle_ctrl #(
    .FRAME_W (FRAME_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .reqStrobe     (reqStrobe),
    .aboveDepth    (aboveDepth),
    .fromVblankIrq (fromVblankIrq),
    .fifoFull      (fifoFull),
    .interlaced    (interlaced),
    .frameCount    (frameCount),
    .strb          (strb)
  );

  sle_datapath #(
    .LINE_W (LINE_W),
    .PIX_W  (PIX_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .bufTop      (bufTop),
    .bufBase     (bufBase),
    .activeWidth (activeWidth),
    .prodLine    (prodLine),
    .vTotal      (vTotal),
    .vActive     (vActive),
    .hTotal      (hTotal),
    .aboveDepth  (aboveDepth),
    .doneStrobe  (doneStrobe),
    .vPos        (vPos),
    .hPos        (hPos),
    .posValid    (posValid),
    .posAccurate (posAccurate),
    .inVblank    (inVblank)
  );

endmodule

// File: tb/tb_scanline_estimator.sv
module tb_scanline_estimator;

  localparam int LINE_W  = 12;
  localparam int PIX_W   = 16;
  localparam int FRAME_W = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               reqStrobe = 1'b0;
  logic [LINE_W-1:0]  prodLine = '0;
  logic [FRAME_W-1:0] frameCount = '0;
  logic               fifoFull = 1'b0;
  logic [PIX_W-1:0]   bufTop = '0;
  logic [PIX_W-1:0]   bufBase = '0;
  logic [LINE_W-1:0]  activeWidth = '0;
  logic [LINE_W-1:0]  vTotal = '0;
  logic [LINE_W-1:0]  vActive = '0;
  logic [LINE_W-1:0]  hTotal = '0;
  logic               interlaced = 1'b0;
  logic               fromVblankIrq = 1'b0;
  logic               doneStrobe;
  logic [LINE_W:0]    vPos;
  logic [LINE_W-1:0]  hPos;
  logic               posValid, posAccurate, inVblank;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  scanline_estimator #(
    .LINE_W (LINE_W), .PIX_W (PIX_W), .FRAME_W (FRAME_W)
  ) dut (
    .clk (clk), .rst_n (rst_n), .reqStrobe (reqStrobe), .prodLine (prodLine),
    .frameCount (frameCount), .fifoFull (fifoFull), .bufTop (bufTop),
    .bufBase (bufBase), .activeWidth (activeWidth), .vTotal (vTotal),
    .vActive (vActive), .hTotal (hTotal), .interlaced (interlaced),
    .fromVblankIrq (fromVblankIrq), .doneStrobe (doneStrobe), .vPos (vPos),
    .hPos (hPos), .posValid (posValid), .posAccurate (posAccurate),
    .inVblank (inVblank)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Drive one query and compare against the requirement model
  task automatic query(input string name, input int pl, input int fc, input int ff,
                       input int top, input int base, input int w, input int vt,
                       input int va, input int ht, input int il, input int irq);
    int size, depth, expPos, expH;
    bit above, expAcc;
    string posTag;
    @(negedge clk);
    prodLine = LINE_W'(pl); frameCount = FRAME_W'(fc); fifoFull = ff[0];
    bufTop = PIX_W'(top); bufBase = PIX_W'(base); activeWidth = LINE_W'(w);
    vTotal = LINE_W'(vt); vActive = LINE_W'(va); hTotal = LINE_W'(ht);
    interlaced = il[0]; fromVblankIrq = irq[0];
    reqStrobe = 1'b1;
    @(negedge clk);
    reqStrobe = 1'b0;
    // R2 R3 model
    size  = (top & ~3) - (base & ~3) + 4;
    depth = (w == 0) ? 32'h7fff_ffff : size / w;
    above = pl > depth;
    if (above) begin
      expPos = pl - depth - 1; expAcc = 1'b1; posTag = "R4";
    end else if (irq != 0) begin
      expPos = -(vt - va); expAcc = (ff == 0); posTag = "R6";
    end else begin
      expPos = 0; expAcc = 1'b0; posTag = "R7";
    end
    expH = (il != 0 && (fc % 2) == 1) ? ht / 2 : 0;
    check({"R1 ", name}, "doneStrobe", int'(doneStrobe), 1);
    check({"R9 ", name}, "posValid", int'(posValid), 1);
    check({posTag, " ", name}, "vPos", int'($signed(vPos)), expPos);
    check({posTag, " ", name}, "posAccurate", int'(posAccurate), int'(expAcc));
    check({"R5 ", name}, "inVblank", int'(inVblank), int'(!above));
    check({"R8 ", name}, "hPos", int'(hPos), expH);
  endtask

  // R1: outputs hold when no strobe arrives
  task automatic holdCheck();
    int p0, h0, a0, b0;
    p0 = int'($signed(vPos)); h0 = int'(hPos); a0 = int'(posAccurate); b0 = int'(inVblank);
    @(negedge clk);
    prodLine = 12'd3000; fromVblankIrq = 1'b1; interlaced = 1'b1;
    frameCount = 8'd1; hTotal = 12'd800; activeWidth = 12'd1;
    repeat (3) @(negedge clk);
    check("R1 hold", "doneStrobe", int'(doneStrobe), 0);
    check("R1 hold", "vPos", int'($signed(vPos)), p0);
    check("R1 hold", "hPos", int'(hPos), h0);
    check("R1 hold", "posAccurate", int'(posAccurate), a0);
    check("R1 hold", "inVblank", int'(inVblank), b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset", "posValid", int'(posValid), 0);
    check("R9 reset", "vPos", int'(vPos), 0);
    check("R9 reset", "hPos", int'(hPos), 0);
    check("R9 reset", "doneStrobe", int'(doneStrobe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset", "posAccurate", int'(posAccurate), 0);
    check("R9 reset", "inVblank", int'(inVblank), 0);

    // depth 4 from size 4100, width 1024 (R2 R3)
    query("R4 active", 100, 2, 1, 'h1003, 'h0002, 1024, 1125, 1080, 2200, 0, 0);
    holdCheck();
    query("R5 at depth", 4, 0, 0, 'h1003, 'h0002, 1024, 1125, 1080, 2200, 0, 0);
    query("R4 depth+1", 5, 0, 0, 'h1003, 'h0002, 1024, 1125, 1080, 2200, 0, 0);
    query("R6 irq empty", 3, 0, 0, 'h1003, 'h0002, 1024, 1125, 1080, 2200, 0, 1);
    query("R6 irq full", 3, 0, 1, 'h1003, 'h0002, 1024, 1125, 1080, 2200, 0, 1);
    query("R7 no irq", 0, 0, 1, 'h1003, 'h0002, 1024, 1125, 1080, 2200, 0, 0);
    query("R8 odd field", 100, 7, 0, 'h1003, 'h0002, 1024, 1125, 1080, 2201, 1, 0);
    query("R8 even field", 100, 6, 0, 'h1003, 'h0002, 1024, 1125, 1080, 2200, 1, 0);
    query("R8 progressive", 100, 7, 0, 'h1003, 'h0002, 1024, 1125, 1080, 2200, 0, 0);
    query("R3 zero width", 4000, 0, 0, 'h1003, 'h0002, 0, 1125, 1080, 2200, 0, 0);
    // R2: low bits of top must be cleared (depth 0, not 1)
    query("R2 top mask", 1, 0, 0, 'h0403, 'h0000, 1029, 525, 480, 800, 0, 0);
    // R2: low bits of base must be cleared (depth 1, not 0)
    query("R2 base mask", 1, 0, 0, 'h0400, 'h0003, 1028, 525, 480, 800, 0, 1);
    // R2: full-range buffer needs the extra size bit
    query("R2 wide size", 4095, 0, 0, 'hFFFC, 'h0000, 16, 525, 480, 800, 0, 0);
    query("R4 large line", 4095, 3, 0, 'h0FFF, 'h0000, 4095, 4095, 4000, 4094, 1, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule